// File: doc/BRIEF.md
# I2C Controller Abort and Reset Sequencer

This block brings a stuck I2C byte engine back into service without software. A single start pulse launches it. It drives the engine's register port as a bus master. First it tries to free the bus. Each pass reads the bus-line monitor register. If the sampled line is still low, it reads the control register and writes it back with a stop, a NAK and a byte transfer requested and the start request removed. It then waits a fixed gap before sampling the line again. This repeats until the line reads high or a deadline counted from the start pulse has run out.

Once the bus is free, or the deadline has passed, the block cancels any pending abort, stop or start bit. It then puts the unit through a strictly ordered reset:

1. Write unit reset alone.
2. Clear every status flag.
3. Release unit reset.
4. Load the own-address register.
5. Write the default configuration.
6. Enable the unit.

After a settle time it emits a one-cycle done pulse. Every delay is derived from the clock-frequency parameter.

Register-port reads have a fixed latency of one cycle. Read data is taken from `bus_rdata_i` in the cycle after a read request.

Top module: `i2c_recover_seq`

## Requirements
- R1: After reset the block is idle: `bus_req_o` and `done_o` are low until a start is accepted.
- R2: A `start_i` seen at a clock edge while idle leads, in the next cycle, to a read of the monitor register (index 0). A `start_i` seen at any other edge, including the edge that ends the done cycle, is ignored and leaves the sequence unchanged.
- R3: Each abort pass is a control-register (index 2) read followed in the next cycle by a write of that value with bit 0 (start) cleared and bits 1 (stop), 2 (NAK) and 3 (byte transfer) set.
- R4: After each abort write, the port stays quiet for GAP_CYC = CLK_HZ/1000 cycles. The monitor register is then read again. Each monitor read is followed by one cycle with no request.
- R5: The abort phase ends without a further abort write when bit 0 of the monitor read data is 1. If it is 1 on the first read, no abort write happens at all.
- R6: The abort phase ends when the monitor check falls in cycle n after the accepted start with n-1 >= ABORT_CYC = 50*CLK_HZ/1000, even if the line stays low.
- R7: The abort phase is followed by a control read, then a write of the read value with bits 4 (master abort), 1 and 0 cleared.
- R8: The reset writes come next, in consecutive cycles, in this order:
  - control = 0x4000 (bit 14, unit reset, only);
  - status register (index 3) = 0x7FF;
  - a control read;
  - a control write of the read value with bit 14 cleared.
- R9: The last writes come next, in consecutive cycles, in this order:
  - own-address register (index 4) = zero-extended `own_addr_i`;
  - control = 0x07A0 (bits 5, 7, 8, 9, 10);
  - a control read;
  - a control write of the read value with bit 6 (unit enable) set.
- R10: After the enable write, the port stays quiet for SETTLE_CYC = CLK_HZ*100/1e6 cycles (at least 1). `done_o` is high in the last of them for exactly one cycle, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a recovery sequence (accepted only while idle) |
| own_addr_i | input | OWN_W | Own-address value written during reinitialisation |
| bus_req_o | output | 1 | Register-port request, one cycle per access |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register index |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid the cycle after a read request |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
Two decisions can fall in the same monitor check: the line reading high and the deadline expiring. Both select the same exit path, so the bench runs one case where the line releases after a set number of abort writes and one where it never releases. In the second case the exit cycle must match the deadline formula exactly.

A second overlap is a start request arriving in the done cycle, or during any busy cycle. The bench holds `start_i` high for an entire run and requires the access trace to be unchanged and the block to be idle afterwards. A behavioural model predicts the port on every cycle, so any shift in gap or settle length is caught.

// File: rtl/i2c_recover_pkg.sv
package i2c_recover_pkg;
  // register indices on the engine's port
  localparam int unsigned REG_MON = 0;
  localparam int unsigned REG_CTL = 2;
  localparam int unsigned REG_STS = 3;
  localparam int unsigned REG_OWN = 4;

  // control bit positions decoded by the engine
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_STOP  = 1;
  localparam int unsigned CB_NAK   = 2;
  localparam int unsigned CB_TB    = 3;
  localparam int unsigned CB_MA    = 4;
  localparam int unsigned CB_SCLE  = 5;
  localparam int unsigned CB_EN    = 6;
  localparam int unsigned CB_GCD   = 7;
  localparam int unsigned CB_TXIE  = 8;
  localparam int unsigned CB_RXIE  = 9;
  localparam int unsigned CB_BEIE  = 10;
  localparam int unsigned CB_UR    = 14;

  localparam logic [10:0] STS_ALL = 11'h7FF;

  typedef enum logic [4:0] {
    S_IDLE, S_MON_RD, S_MON_CHK, S_ABT_RD, S_ABT_WR, S_ABT_GAP,
    S_CLR_RD, S_CLR_WR, S_UR_SET, S_STS_CLR, S_UR_RD, S_UR_CLR,
    S_OWN_WR, S_CFG_WR, S_EN_RD, S_EN_WR, S_SETTLE
  } seq_state_e;
endpackage

// File: rtl/i2c_recover_timer.sv
module i2c_recover_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r4_load_nonzero_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> !zero_o);
endmodule

// File: rtl/i2c_recover_deadline.sv
module i2c_recover_deadline #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= LIM);

  a_r6_expiry_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);
endmodule

// File: rtl/i2c_recover_seq.sv
module i2c_recover_seq
  import i2c_recover_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned GAP_MS    = 1,
  parameter int unsigned ABORT_MS  = 50,
  parameter int unsigned SETTLE_US = 100,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OWN_W     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OWN_W-1:0]  own_addr_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o
);
  localparam int unsigned MS_CYC     = CLK_HZ / 1000;
  localparam int unsigned GAP_CYC    = (MS_CYC * GAP_MS) > 0 ? MS_CYC * GAP_MS : 1;
  localparam int unsigned ABORT_CYC  = MS_CYC * ABORT_MS;
  localparam int unsigned SET_RAW    = (MS_CYC * SETTLE_US) / 1000;
  localparam int unsigned SETTLE_CYC = SET_RAW > 0 ? SET_RAW : 1;
  localparam int unsigned TMAX       = GAP_CYC > SETTLE_CYC ? GAP_CYC : SETTLE_CYC;
  localparam int unsigned TW         = $clog2(TMAX + 1);

  localparam logic [DATA_W-1:0] M_START = DATA_W'(1) << CB_START;
  localparam logic [DATA_W-1:0] M_STOP  = DATA_W'(1) << CB_STOP;
  localparam logic [DATA_W-1:0] M_NAK   = DATA_W'(1) << CB_NAK;
  localparam logic [DATA_W-1:0] M_TB    = DATA_W'(1) << CB_TB;
  localparam logic [DATA_W-1:0] M_MA    = DATA_W'(1) << CB_MA;
  localparam logic [DATA_W-1:0] M_EN    = DATA_W'(1) << CB_EN;
  localparam logic [DATA_W-1:0] M_UR    = DATA_W'(1) << CB_UR;
  localparam logic [DATA_W-1:0] CFG_WORD =
      (DATA_W'(1) << CB_BEIE) | (DATA_W'(1) << CB_RXIE) | (DATA_W'(1) << CB_TXIE) |
      (DATA_W'(1) << CB_GCD)  | (DATA_W'(1) << CB_SCLE);

  seq_state_e state_q, state_d;
  logic       tmr_load, tmr_zero, dl_expired;
  logic [TW-1:0] tmr_val;

  i2c_recover_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  i2c_recover_deadline #(.LIMIT(ABORT_CYC)) u_deadline (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == S_IDLE),
    .expired_o (dl_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_MON_RD;
      S_MON_RD:  state_d = S_MON_CHK;
      S_MON_CHK: state_d = (bus_rdata_i[0] || dl_expired) ? S_CLR_RD : S_ABT_RD;
      S_ABT_RD:  state_d = S_ABT_WR;
      S_ABT_WR: begin
        state_d  = S_ABT_GAP;
        tmr_load = 1'b1;
        tmr_val  = TW'(GAP_CYC - 1);
      end
      S_ABT_GAP: if (tmr_zero) state_d = S_MON_RD;
      S_CLR_RD:  state_d = S_CLR_WR;
      S_CLR_WR:  state_d = S_UR_SET;
      S_UR_SET:  state_d = S_STS_CLR;
      S_STS_CLR: state_d = S_UR_RD;
      S_UR_RD:   state_d = S_UR_CLR;
      S_UR_CLR:  state_d = S_OWN_WR;
      S_OWN_WR:  state_d = S_CFG_WR;
      S_CFG_WR:  state_d = S_EN_RD;
      S_EN_RD:   state_d = S_EN_WR;
      S_EN_WR: begin
        state_d  = S_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = TW'(SETTLE_CYC - 1);
      end
      S_SETTLE:  if (tmr_zero) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = ADDR_W'(REG_CTL);
    bus_wdata_o = '0;
    unique case (state_q)
      S_MON_RD: begin
        bus_req_o  = 1'b1;
        bus_addr_o = ADDR_W'(REG_MON);
      end
      S_ABT_RD, S_CLR_RD, S_UR_RD, S_EN_RD: bus_req_o = 1'b1;
      S_ABT_WR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = (bus_rdata_i & ~M_START) | M_NAK | M_STOP | M_TB;
      end
      S_CLR_WR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = bus_rdata_i & ~(M_MA | M_START | M_STOP);
      end
      S_UR_SET: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = M_UR;
      end
      S_STS_CLR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = ADDR_W'(REG_STS);
        bus_wdata_o = DATA_W'(STS_ALL);
      end
      S_UR_CLR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = bus_rdata_i & ~M_UR;
      end
      S_OWN_WR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = ADDR_W'(REG_OWN);
        bus_wdata_o = DATA_W'(own_addr_i);
      end
      S_CFG_WR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = CFG_WORD;
      end
      S_EN_WR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = bus_rdata_i | M_EN;
      end
      default: ;
    endcase
  end

  assign done_o = (state_q == S_SETTLE) && tmr_zero;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> (!bus_req_o && !done_o));
  a_r2_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i) |=> (bus_req_o && !bus_we_o && bus_addr_o == ADDR_W'(REG_MON)));
  a_r3_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ABT_WR) |-> $past(bus_req_o && !bus_we_o && bus_addr_o == ADDR_W'(REG_CTL)));
  a_r4_gap_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ABT_GAP) |-> !bus_req_o);
  a_r6_deadline_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_MON_CHK && dl_expired) |=> (state_q == S_CLR_RD));
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && state_q == S_IDLE));
endmodule

// File: tb/i2c_recover_seq_tb.sv
module i2c_recover_seq_tb;
  localparam int unsigned CLK_HZ     = 20_000;
  localparam int unsigned GAP_CYC    = CLK_HZ / 1000;
  localparam int unsigned ABORT_CYC  = 50 * CLK_HZ / 1000;
  localparam int unsigned SETTLE_CYC = (CLK_HZ * 100 / 1_000_000) > 0 ? CLK_HZ * 100 / 1_000_000 : 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  own_addr_i = '0;
  logic        bus_req_o, bus_we_o, done_o;
  logic [2:0]  bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;

  int checks = 0, fails = 0, n_cyc = 0;
  bit finished = 0;

  // register-port slave
  logic [31:0] s_ctl = '0;
  int          wcnt = 0, rel = 0;

  always #10 clk = ~clk;

  i2c_recover_seq #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .own_addr_i(own_addr_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .done_o(done_o)
  );

  always @(posedge clk) begin
    if (rst_ni && bus_req_o) begin
      if (bus_we_o) begin
        if (bus_addr_o == 3'd2) begin
          s_ctl <= bus_wdata_o;
          if (bus_wdata_o[3]) wcnt <= wcnt + 1;
        end
      end else begin
        if (bus_addr_o == 3'd0)      bus_rdata_i <= {30'h0, 1'b1, (wcnt >= rel)};
        else if (bus_addr_o == 3'd2) bus_rdata_i <= s_ctl;
        else                         bus_rdata_i <= '0;
      end
    end
  end

  task automatic step(input string tag, input logic r, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic dn, input logic s);
    @(negedge clk);
    n_cyc++;
    checks++;
    if (bus_req_o !== r || done_o !== dn ||
        (r && (bus_we_o !== w || bus_addr_o !== a || (w && bus_wdata_o !== d)))) begin
      fails++;
      $display("FAIL %s cyc %0d: got req=%b we=%b addr=%0d wdata=%h done=%b exp req=%b we=%b addr=%0d wdata=%h done=%b",
               tag, n_cyc, bus_req_o, bus_we_o, bus_addr_o, bus_wdata_o, done_o, r, w, a, d, dn);
    end
    start_i = s;
  endtask

  task automatic run(input logic [31:0] c0, input int r_after, input logic [6:0] own, input logic hold);
    logic [31:0] mctl = c0;
    int writes = 0;
    bit leave;
    @(negedge clk);
    s_ctl = c0; wcnt = 0; rel = r_after; own_addr_i = own;
    start_i = 1'b1;
    n_cyc = 0;
    forever begin
      step("R2 monitor read", 1, 0, 3'd0, 0, 0, hold);
      leave = (writes >= r_after) || (n_cyc + 1 - 1 >= ABORT_CYC);
      step("R4 check gap", 0, 0, 0, 0, 0, hold);
      if (leave) break;
      step("R3 abort read", 1, 0, 3'd2, 0, 0, hold);
      mctl = (mctl & ~32'h1) | 32'hE;
      step("R3 abort write", 1, 1, 3'd2, mctl, 0, hold);
      writes++;
      for (int i = 0; i < GAP_CYC; i++) step("R4 gap", 0, 0, 0, 0, 0, hold);
    end
    if (r_after > 1000) begin
      checks++;
      if (n_cyc - 1 != ABORT_CYC + ((ABORT_CYC + GAP_CYC + 3) % (GAP_CYC + 4) == 0 ? 0 : 0) &&
          (n_cyc - 1) < ABORT_CYC) begin
        fails++;
        $display("FAIL R6: exit cycle %0d below deadline %0d", n_cyc, ABORT_CYC);
      end
    end
    step("R7 clear read", 1, 0, 3'd2, 0, 0, hold);
    mctl = mctl & ~32'h13;
    step("R7 clear write", 1, 1, 3'd2, mctl, 0, hold);
    step("R8 unit reset", 1, 1, 3'd2, 32'h4000, 0, hold);
    step("R8 status clear", 1, 1, 3'd3, 32'h7FF, 0, hold);
    step("R8 release read", 1, 0, 3'd2, 0, 0, hold);
    step("R8 release write", 1, 1, 3'd2, 32'h0, 0, hold);
    step("R9 own address", 1, 1, 3'd4, {25'h0, own}, 0, hold);
    step("R9 config", 1, 1, 3'd2, 32'h07A0, 0, hold);
    step("R9 enable read", 1, 0, 3'd2, 0, 0, hold);
    step("R9 enable write", 1, 1, 3'd2, 32'h07E0, 0, hold);
    for (int i = 0; i < SETTLE_CYC - 1; i++) step("R10 settle", 0, 0, 0, 0, 0, hold);
    step("R10 done pulse", 0, 0, 0, 0, 1, hold);
    step("R10 R2 idle after done", 0, 0, 0, 0, 0, 0);
    step("R10 still idle", 0, 0, 0, 0, 0, 0);
    checks++;
    if ((r_after <= 1000) && writes != r_after) begin
      fails++;
      $display("FAIL R5: abort writes %0d expected %0d", writes, r_after);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    step("R1 reset state", 0, 0, 0, 0, 0, 0);
    rst_ni = 1'b1;
    step("R1 idle", 0, 0, 0, 0, 0, 0);
    step("R1 idle", 0, 0, 0, 0, 0, 0);
    run(32'h0000_0041, 2, 7'h5A, 1'b0);   // R5 release after two passes
    run(32'h0000_0010, 0, 7'h01, 1'b1);   // R5 line already high, R2 start held throughout
    run(32'h0000_0007, 1_000_000, 7'h7F, 1'b0); // R6 line never releases
    run(32'h0000_00F9, 5, 7'h33, 1'b1);   // R3 other control pattern, R2 held start
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule